// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches eight external interrupt pins and turns their activity into one prioritized interrupt request for a processor core. The lower four pins are always sensed as active-low levels. The upper four pins each take a two-bit sense code, which selects low-level, falling-edge or rising-edge detection. For edge detection, a flag register latches each edge event until software or the core retires it.

Every pin passes through a two-flop synchronizer first. Edges are found by comparing the synchronized sample with the sample taken one cycle earlier. Three byte-wide registers sit behind a plain write-strobe and address interface: sense codes, enable mask and edge flags. A global interrupt enable input gates every request. When more than one channel requests, the lowest channel number wins. The winner is presented as a valid bit plus a 3-bit index. An acknowledge pulse from the core clears the edge flag of the indexed channel.

Top module: `irq_sense_ctrl`

## Requirements
- R1: After reset, the sense register, the mask register and the flag register all read 0, and `irqValid` is 0 while all pins are high.
- R2: Register address 0 is the sense register, address 1 is the mask register and address 2 is the flag register. Written values read back combinationally on `rdData`. Address 3 reads 0. Flag bits 3:0 always read 0.
- R3: Channels 0 to 3 request while their synchronized pin is low. A pin change reaches `irqValid`/`irqIndex` after the second rising clock edge that follows it.
- R4: Channel 4+k uses sense bits [2k+1:2k], and the upper bit of the pair is bit 1 of the code. Code 00 is low level, 10 is falling edge, 11 is rising edge. Code 01 produces no request.
- R5: In edge mode, the selected edge sets flag bit 4+k. The flag is visible after the third rising edge that follows the pin change, and it requests until cleared.
- R6: Writing the flag register clears every flag whose written bit is 1. Bits written as 0 leave their flags unchanged.
- R7: A high `irqAck` while `irqValid` is 1 clears the flag of the channel at `irqIndex` only. If a new edge sets that flag in the same cycle, the set wins.
- R8: While a channel's code is 00 or 01, its flag is held at 0 and reads 0. A flag does not come back when the channel returns to edge mode.
- R9: A channel reaches the output only when its mask bit and `gie` are both 1. Flags still set while the channel is masked or `gie` is low.
- R10: When several channels request, `irqIndex` is the lowest requesting channel number.
- R11: A pulse held for two clock periods on an edge-mode pin sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| gie | input | 1 | Global interrupt enable |
| pinIn | input | 8 | External interrupt pins, asynchronous |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address for reads and writes |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data for `addr` |
| irqAck | input | 1 | Core acknowledge of the presented request |
| irqValid | output | 1 | A masked, enabled request is pending |
| irqIndex | output | 3 | Channel number of the winning request |

## Verification
The bench sweeps every sense code on every configurable channel, for both a falling and a rising transition. A swapped bit pair or a mis-decoded code would set the wrong flag, or would let the reserved code request. It sweeps all 255 non-zero mask patterns with every channel requesting, and all 16 low-channel pin patterns. A priority encoder that picks the highest channel, or drops a channel, gives the wrong index. It times an acknowledge into the same cycle as a fresh edge, so a design that lets the clear win loses the interrupt. It also switches a flagged channel to level mode and back, so a flag that is only masked on read would come back as a stale request.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;
  localparam int CH_N   = 8;
  localparam int LVL_N  = 4;
  localparam int CODE_W = 2;
  localparam int DATA_W = CH_N;
  localparam int ADDR_W = 2;
  localparam int IDX_W  = $clog2(CH_N);

  localparam logic [ADDR_W-1:0] ADDR_SENSE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLAG  = 2'd2;

  typedef enum logic [CODE_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_RSVD = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  typedef struct packed {
    logic            wrSense;
    logic            wrMask;
    logic            wrFlag;
    logic [CH_N-1:0] ackClr;
  } strobe_t;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int   WIDTH     = 8,
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stageIn;
      if (s == 0) begin : g_first
        assign stageIn = din;
      end else begin : g_next
        assign stageIn = stageQ[s-1];
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= {WIDTH{RESET_VAL}};
        else       stageQ[s] <= stageIn;
      end
    end
  endgenerate

  assign dout = stageQ[STAGES-1];
endmodule

// File: rtl/irq_sense_dp.sv
module irq_sense_dp
  import irq_sense_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              gie,
  input  logic [CH_N-1:0]   pinIn,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CH_N-1:0]   reqVec
);
  localparam int EDGE_N  = CH_N - LVL_N;
  localparam int SENSE_W = CODE_W * EDGE_N;

  logic [CH_N-1:0]    curPin, prevPin;
  logic [SENSE_W-1:0] senseReg;
  logic [CH_N-1:0]    maskReg;
  logic [CH_N-1:0]    flagReg, flagNext;
  logic [CH_N-1:0]    edgeVec, setEv, rawReq;

  irq_pin_sync #(.WIDTH(CH_N), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (pinIn),
    .dout(curPin)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevPin <= '1;
    else       prevPin <= curPin;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      senseReg <= '0;
      maskReg  <= '0;
    end else begin
      if (strobe.wrSense) senseReg <= wrData[SENSE_W-1:0];
      if (strobe.wrMask)  maskReg  <= wrData;
    end
  end

  generate
    for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
      if (ch < LVL_N) begin : g_level
        assign edgeVec[ch]  = 1'b0;
        assign setEv[ch]    = 1'b0;
        assign flagNext[ch] = 1'b0;
        assign rawReq[ch]   = ~curPin[ch];
      end else begin : g_cfg
        localparam int BASE = CODE_W * (ch - LVL_N);
        sense_e code;
        logic   clrHit;
        assign code        = sense_e'(senseReg[BASE +: CODE_W]);
        assign edgeVec[ch] = (code == SENSE_FALL) || (code == SENSE_RISE);
        assign setEv[ch]   = ((code == SENSE_FALL) && prevPin[ch] && !curPin[ch]) ||
                             ((code == SENSE_RISE) && !prevPin[ch] && curPin[ch]);
        assign clrHit      = (strobe.wrFlag && wrData[ch]) || strobe.ackClr[ch];
        always_comb begin
          if (!edgeVec[ch])    flagNext[ch] = 1'b0;
          else if (setEv[ch])  flagNext[ch] = 1'b1;
          else if (clrHit)     flagNext[ch] = 1'b0;
          else                 flagNext[ch] = flagReg[ch];
        end
        always_comb begin
          case (code)
            SENSE_LOW:  rawReq[ch] = ~curPin[ch];
            SENSE_FALL,
            SENSE_RISE: rawReq[ch] = flagReg[ch];
            default:    rawReq[ch] = 1'b0;
          endcase
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagReg <= '0;
    else       flagReg <= flagNext;
  end

  assign reqVec = rawReq & maskReg & {CH_N{gie}};

  always_comb begin
    case (addr)
      ADDR_SENSE: rdData = DATA_W'(senseReg);
      ADDR_MASK:  rdData = maskReg;
      ADDR_FLAG:  rdData = flagReg & edgeVec;
      default:    rdData = '0;
    endcase
  end

  // R9: nothing leaves the datapath while the global enable is low
  assert_gie_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    !gie |-> (reqVec == '0));

  // R8: a channel outside edge mode has no flag one cycle later
  assert_flag_zero_level_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|(~edgeVec)) |=> ((flagReg & ~$past(edgeVec)) == '0));

  // R6: write-one-to-clear takes effect unless an edge lands on that bit
  assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrFlag |=> ((flagReg & $past(wrData & ~setEv)) == '0));

  // R7: an acknowledged flag is cleared unless an edge lands on it
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|(strobe.ackClr & ~setEv)) |=> ((flagReg & $past(strobe.ackClr & ~setEv)) == '0));

  // R5: a detected edge always leaves its flag set, whatever clear arrives
  assert_edge_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|setEv) |=> ((flagReg & $past(setEv)) == $past(setEv)));
endmodule

// File: rtl/irq_sense_ctl.sv
module irq_sense_ctl
  import irq_sense_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              irqAck,
  input  logic [CH_N-1:0]   reqVec,
  output strobe_t           strobe,
  output logic              irqValid,
  output logic [IDX_W-1:0]  irqIndex
);
  always_comb begin
    irqValid = 1'b0;
    irqIndex = '0;
    for (int i = CH_N - 1; i >= 0; i--) begin
      if (reqVec[i]) begin
        irqValid = 1'b1;
        irqIndex = IDX_W'(i);
      end
    end
  end

  always_comb begin
    strobe.wrSense = wrEn && (addr == ADDR_SENSE);
    strobe.wrMask  = wrEn && (addr == ADDR_MASK);
    strobe.wrFlag  = wrEn && (addr == ADDR_FLAG);
    strobe.ackClr  = (irqAck && irqValid) ? (CH_N'(1) << irqIndex) : '0;
  end

  // R10: the presented channel requests and no lower channel does
  assert_lowest_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (reqVec[irqIndex] &&
                  ((reqVec & ((CH_N'(1) << irqIndex) - CH_N'(1))) == '0)));

  // R10: no valid without a request, and no request without valid
  assert_valid_tracks_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    !irqValid |-> (reqVec == '0));

  // R7: an acknowledge touches at most one channel
  assert_ack_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.ackClr));
endmodule

// File: rtl/irq_sense_ctrl.sv
module irq_sense_ctrl
  import irq_sense_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        gie,
  input  logic [7:0]  pinIn,
  input  logic        wrEn,
  input  logic [1:0]  addr,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  input  logic        irqAck,
  output logic        irqValid,
  output logic [2:0]  irqIndex
);
  strobe_t         strobe;
  logic [CH_N-1:0] reqVec;

  irq_sense_ctl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .addr    (addr),
    .irqAck  (irqAck),
    .reqVec  (reqVec),
    .strobe  (strobe),
    .irqValid(irqValid),
    .irqIndex(irqIndex)
  );

  irq_sense_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .gie   (gie),
    .pinIn (pinIn),
    .strobe(strobe),
    .addr  (addr),
    .wrData(wrData),
    .rdData(rdData),
    .reqVec(reqVec)
  );
endmodule

// File: tb/irq_sense_ctrl_tb.sv
module irq_sense_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       gie = 1'b0;
  logic [7:0] pinIn = 8'hFF;
  logic       wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       irqAck = 1'b0;
  logic       irqValid;
  logic [2:0] irqIndex;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_sense_ctrl u_dut (
    .clk(clk), .rstN(rstN), .gie(gie), .pinIn(pinIn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqAck(irqAck),
    .irqValid(irqValid), .irqIndex(irqIndex)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  function automatic int lowestBit(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic chkIrq(input string tag, input logic [7:0] reqs);
    chk({tag, " valid"}, int'(irqValid), int'(reqs != 8'h00));
    if (reqs != 8'h00) chk({tag, " index"}, int'(irqIndex), lowestBit(reqs));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    waitN(3);
    rstN = 1'b1;
    waitN(1);

    // R1 reset state
    regRead(2'd0, rd); chk("R1 sense", rd, 0);
    regRead(2'd1, rd); chk("R1 mask", rd, 0);
    regRead(2'd2, rd); chk("R1 flag", rd, 0);
    chk("R1 valid", irqValid, 0);

    // R2 register map and readback
    regWrite(2'd0, 8'hA5); regRead(2'd0, rd); chk("R2 sense readback", rd, 8'hA5);
    regWrite(2'd1, 8'h3C); regRead(2'd1, rd); chk("R2 mask readback", rd, 8'h3C);
    regRead(2'd3, rd); chk("R2 unmapped address", rd, 0);
    regWrite(2'd0, 8'h00); regWrite(2'd1, 8'h00);
    pinIn = 8'h00; waitN(3);
    regRead(2'd2, rd); chk("R2 flag low nibble", rd, 0);
    pinIn = 8'hFF; waitN(3);

    gie = 1'b1;

    // R3 level channels: all 16 pin patterns, timing at second edge
    regWrite(2'd1, 8'h0F);
    for (int p = 0; p < 16; p++) begin
      pinIn = {4'hF, 4'(p)};
      waitN(1);
      chkIrq("R3 before sync", ~{4'hF, 4'((p == 0) ? 15 : p - 1)});
      waitN(1);
      chkIrq("R3 level", ~{4'hF, 4'(p)});
    end
    pinIn = 8'hFF; waitN(3);

    // R4 R5 R8 sweep of codes on channels 4..7, both transitions
    for (int c = 4; c < 8; c++) begin
      for (int code = 0; code < 4; code++) begin
        regWrite(2'd1, 8'(1 << c));
        regWrite(2'd0, 8'(code << (2 * (c - 4))));
        regWrite(2'd2, 8'hFF);
        pinIn[c] = 1'b0; waitN(3);
        regRead(2'd2, rd);
        chk($sformatf("R4 R5 R8 fall ch%0d code%0d flag", c, code), rd, (code == 2) ? (1 << c) : 0);
        chkIrq($sformatf("R4 fall ch%0d code%0d", c, code),
               ((code == 2) || (code == 0)) ? 8'(1 << c) : 8'h00);
        regWrite(2'd2, 8'hFF);
        pinIn[c] = 1'b1; waitN(3);
        regRead(2'd2, rd);
        chk($sformatf("R4 R5 R8 rise ch%0d code%0d flag", c, code), rd, (code == 3) ? (1 << c) : 0);
        chkIrq($sformatf("R4 rise ch%0d code%0d", c, code), (code == 3) ? 8'(1 << c) : 8'h00);
        regWrite(2'd2, 8'hFF);
      end
    end
    regWrite(2'd0, 8'h00);

    // R7 acknowledge clears the indexed flag only (ch4, ch6 falling)
    regWrite(2'd0, 8'h22); regWrite(2'd1, 8'h50); regWrite(2'd2, 8'hFF);
    pinIn[4] = 1'b0; pinIn[6] = 1'b0; waitN(3);
    chkIrq("R7 two flags", 8'h50);
    irqAck = 1'b1; waitN(1); irqAck = 1'b0;
    regRead(2'd2, rd); chk("R7 ack clears ch4 only", rd, 8'h40);
    chkIrq("R7 next winner", 8'h40);
    irqAck = 1'b1; waitN(1); irqAck = 1'b0;
    regRead(2'd2, rd); chk("R7 ack clears ch6", rd, 0);
    chk("R7 valid after acks", irqValid, 0);

    // R7 set wins over acknowledge in the same cycle (ch4)
    pinIn[4] = 1'b1; pinIn[6] = 1'b1; waitN(3);
    pinIn[4] = 1'b0; waitN(3);
    pinIn[4] = 1'b1; waitN(3);
    regRead(2'd2, rd); chk("R7 flag armed", rd, 8'h10);
    pinIn[4] = 1'b0; waitN(2);
    irqAck = 1'b1; waitN(1); irqAck = 1'b0;
    regRead(2'd2, rd); chk("R7 set beats ack", rd, 8'h10);
    irqAck = 1'b1; waitN(1); irqAck = 1'b0;
    pinIn[4] = 1'b1; waitN(3);

    // R6 write-one-to-clear, R9 masking and global enable
    regWrite(2'd2, 8'hFF); regWrite(2'd1, 8'h00);
    pinIn[4] = 1'b0; pinIn[6] = 1'b0; waitN(3);
    regRead(2'd2, rd); chk("R9 flags set while masked", rd, 8'h50);
    chk("R9 masked no valid", irqValid, 0);
    regWrite(2'd1, 8'h50); gie = 1'b0; waitN(1);
    chk("R9 gie low no valid", irqValid, 0);
    gie = 1'b1; waitN(1);
    chkIrq("R9 gie high", 8'h50);
    regWrite(2'd2, 8'h00); regRead(2'd2, rd); chk("R6 write zero keeps", rd, 8'h50);
    regWrite(2'd2, 8'h10); regRead(2'd2, rd); chk("R6 clear ch4", rd, 8'h40);

    // R8 switching to level mode drops the flag, and it stays gone
    pinIn[6] = 1'b1; waitN(3);
    regWrite(2'd0, 8'h02); regRead(2'd2, rd); chk("R8 level drops flag", rd, 0);
    regWrite(2'd0, 8'h22); regRead(2'd2, rd); chk("R8 no stale flag", rd, 0);
    chk("R8 no stale request", irqValid, 0);
    pinIn[4] = 1'b1; waitN(3);

    // R11 two-cycle pulses: low on ch4 (falling), high on ch7 (rising)
    regWrite(2'd0, 8'hC2); regWrite(2'd1, 8'h90);
    pinIn[7] = 1'b0; waitN(3);
    regWrite(2'd2, 8'hFF);
    pinIn[4] = 1'b0; pinIn[7] = 1'b1; waitN(2);
    pinIn[4] = 1'b1; pinIn[7] = 1'b0; waitN(2);
    regRead(2'd2, rd); chk("R11 short pulses caught", rd, 8'h90);
    chkIrq("R11 pulse request", 8'h90);
    regWrite(2'd2, 8'hFF); regWrite(2'd0, 8'h00);

    // R10 priority over every mask pattern, all channels requesting
    pinIn = 8'h00; waitN(3);
    for (int m = 1; m < 256; m++) begin
      regWrite(2'd1, 8'(m));
      chkIrq($sformatf("R10 mask %0d", m), 8'(m));
    end
    pinIn = 8'hFF; waitN(3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule